// File: doc/BRIEF.md
# Hash Accelerator Status and Interrupt Controller

This block keeps the status flags and the interrupt-enable bits of a hash accelerator and folds them into a single interrupt request. The datapath reports events to it as one-cycle strobes: a block started, a block finished, the final digest finished, the input buffer drained, a data word was written, and an init command was issued. It also follows a DMA enable bit and whether a DMA transfer is still in flight. Software sees everything through a small register port. It has a status register whose two event flags are cleared by writing 0 to them. It also has an enable register that selects which flags may raise the interrupt.

The flags do not all clear the same way. The input-ready flag comes out of reset set. It clears either when software writes 0 to it or when any data word is written. The digest flag clears either when software writes 0 to it or on init. In every case a hardware set in the same cycle as a clear wins. The DMA indication stays high while a transfer is still in flight, even after software turns DMA enable off. All pins are plain control and status signals. No stream interface is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `hash_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00000001 (only input-ready set), the enable register reads 0 and `irq` is 0.
- R2: The digest flag (status bit 1) sets one cycle after `final_done`. It clears after a status write with bit 1 = 0, or after `init_cmd`. A status write with bit 1 = 1 leaves it unchanged.
- R3: The input-ready flag (status bit 0) sets one cycle after `buf_empty`. It clears after a status write with bit 0 = 0, or after `din_wr`. A status write with bit 0 = 1 leaves it unchanged.
- R4: When a set event and any clear event for the same flag arrive in the same cycle, the flag is 1 afterwards.
- R5: `irq` equals (status bit 1 AND enable bit 1) OR (status bit 0 AND enable bit 0), where an enable bit of 1 unmasks its source.
- R6: Enable register writes (`reg_addr` = 1) store `reg_wdata[1:0]`. Enable bits 31:2 always read 0.
- R7: The busy bit (status bit 3) sets one cycle after `blk_start` and clears after `blk_done` or `init_cmd`. If `blk_start` and a clear arrive together, the bit stays set.
- R8: Status bit 2 (DMA active) is 1 while DMA enable is 1 or a transfer is in flight. A transfer becomes in flight on `dma_req` and stops being in flight on `dma_done` or `init_cmd`. Clearing DMA enable does not end a transfer that is in flight.
- R9: DMA enable loads `dma_en_val` on `dma_en_wr` and is cleared by `dma_tc`. `dma_tc` wins over a same-cycle write. `init_cmd` does not change DMA enable.
- R10: Status writes have no effect on status bits 3 and 2. Status bits 31:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Datapath began processing a block |
| blk_done | input | 1 | Datapath finished a block |
| final_done | input | 1 | Final digest of the message is complete |
| buf_empty | input | 1 | Input buffer has all locations free |
| din_wr | input | 1 | A data word was written to the input |
| init_cmd | input | 1 | Init command for a new message |
| dma_en_wr | input | 1 | Write strobe for DMA enable |
| dma_en_val | input | 1 | Value written to DMA enable |
| dma_req | input | 1 | A DMA transfer was requested |
| dma_done | input | 1 | The requested DMA transfer completed |
| dma_tc | input | 1 | Terminal-count transfer of the message |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read value of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Every flag, DMA enable and the enable bits are registered. Their new value therefore appears on `reg_rdata` and `irq` one clock after the strobe or write that caused it. `reg_rdata` itself follows `reg_addr` within the same cycle. The bench drives inputs just after the falling edge and lets the rising edge act on them. It compares `reg_rdata` and `irq` against its reference model at the next falling edge, when the one-cycle update is complete. Directed reads change `reg_addr` and sample half a clock phase later. This stays inside the same low phase, so the register value being read cannot move before it is sampled.

// File: rtl/hash_irq_pkg.sv
package hash_irq_pkg;
  localparam int NUM_SRC  = 2;
  localparam int RDY_BIT  = 0;
  localparam int DIG_BIT  = 1;
  localparam int DMA_BIT  = 2;
  localparam int BUSY_BIT = 3;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/dma_tracker.sv
module dma_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr_i,
  input  logic en_val_i,
  input  logic tc_i,
  input  logic req_i,
  input  logic done_i,
  input  logic init_i,
  output logic active_o
);
  logic en_q;
  logic inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (tc_i)     en_q <= 1'b0;
    else if (en_wr_i)  en_q <= en_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 inflight_q <= 1'b0;
    else if (req_i)             inflight_q <= 1'b1;
    else if (done_i || init_i)  inflight_q <= 1'b0;
  end

  assign active_o = en_q | inflight_q;

  assert_tc_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_i |=> !en_q);
  assert_inflight_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q && !done_i && !init_i) |=> active_o);
  assert_req_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> active_o);
endmodule

// File: rtl/hash_irq_ctrl.sv
module hash_irq_ctrl
  import hash_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              blk_done,
  input  logic              final_done,
  input  logic              buf_empty,
  input  logic              din_wr,
  input  logic              init_cmd,
  input  logic              dma_en_wr,
  input  logic              dma_en_val,
  input  logic              dma_req,
  input  logic              dma_done,
  input  logic              dma_tc,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic               stat_wr;
  logic               ien_wr;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] src_clr;
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] ien_q;
  logic               busy_q;
  logic               dma_active;
  logic [DATA_W-1:0]  status_word;
  logic [DATA_W-1:0]  enable_word;

  assign stat_wr = reg_wr && (reg_addr == ADDR_STATUS);
  assign ien_wr  = reg_wr && (reg_addr == ADDR_ENABLE);

  always_comb begin
    src_set          = '0;
    src_clr          = '0;
    src_set[RDY_BIT] = buf_empty;
    src_clr[RDY_BIT] = din_wr || (stat_wr && !reg_wdata[RDY_BIT]);
    src_set[DIG_BIT] = final_done;
    src_clr[DIG_BIT] = init_cmd || (stat_wr && !reg_wdata[DIG_BIT]);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    sticky_flag #(.RST_VAL(i == RDY_BIT)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_set[i]),
      .clr_i (src_clr[i]),
      .q_o   (src_q[i])
    );
  end

  sticky_flag #(.RST_VAL(1'b0)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (blk_start),
    .clr_i (blk_done || init_cmd),
    .q_o   (busy_q)
  );

  dma_tracker u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr_i  (dma_en_wr),
    .en_val_i (dma_en_val),
    .tc_i     (dma_tc),
    .req_i    (dma_req),
    .done_i   (dma_done),
    .init_i   (init_cmd),
    .active_o (dma_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= reg_wdata[NUM_SRC-1:0];
  end

  always_comb begin
    status_word                = '0;
    status_word[NUM_SRC-1:0]   = src_q;
    status_word[DMA_BIT]       = dma_active;
    status_word[BUSY_BIT]      = busy_q;
    enable_word                = '0;
    enable_word[NUM_SRC-1:0]   = ien_q;
  end

  assign reg_rdata = (reg_addr == ADDR_ENABLE) ? enable_word : status_word;
  assign irq       = |(src_q & ien_q);

  assert_irq_digest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (final_done && ien_q[DIG_BIT] && !ien_wr) |=> irq);
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && reg_wdata[NUM_SRC-1:0] == '0) |=> !irq);
  assert_enable_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_ENABLE) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0));
  assert_busy_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !blk_start && !blk_done && !init_cmd) |=> $stable(busy_q));
endmodule

// File: tb/hash_irq_ctrl_test.sv
`timescale 1ns/100ps
module hash_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 0, blk_done = 0, final_done = 0, buf_empty = 0;
  logic din_wr = 0, init_cmd = 0, dma_en_wr = 0, dma_en_val = 0;
  logic dma_req = 0, dma_done = 0, dma_tc = 0, reg_wr = 0, reg_addr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  bit m_rdy, m_dig, m_busy, m_den, m_inf;
  bit [1:0] m_ien;

  always #2 clk = ~clk;

  hash_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_done(blk_done),
    .final_done(final_done), .buf_empty(buf_empty), .din_wr(din_wr),
    .init_cmd(init_cmd), .dma_en_wr(dma_en_wr), .dma_en_val(dma_en_val),
    .dma_req(dma_req), .dma_done(dma_done), .dma_tc(dma_tc),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic bit [31:0] model_read(bit addr);
    if (addr) return {30'd0, m_ien};
    return {28'd0, m_busy, (m_den || m_inf), m_dig, m_rdy};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 1; m_dig = 0; m_busy = 0; m_den = 0; m_inf = 0; m_ien = 0;
    end else begin
      bit swr, ewr;
      swr = reg_wr && !reg_addr;
      ewr = reg_wr && reg_addr;
      if (buf_empty) m_rdy = 1;
      else if (din_wr || (swr && !reg_wdata[0])) m_rdy = 0;
      if (final_done) m_dig = 1;
      else if (init_cmd || (swr && !reg_wdata[1])) m_dig = 0;
      if (blk_start) m_busy = 1;
      else if (blk_done || init_cmd) m_busy = 0;
      if (dma_tc) m_den = 0;
      else if (dma_en_wr) m_den = dma_en_val;
      if (dma_req) m_inf = 1;
      else if (dma_done || init_cmd) m_inf = 0;
      if (ewr) m_ien = reg_wdata[1:0];
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("model rdata", reg_rdata, model_read(reg_addr));
      check("model irq", {31'd0, irq},
            {31'd0, (m_dig && m_ien[1]) || (m_rdy && m_ien[0])});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
    blk_start = 0; blk_done = 0; final_done = 0; buf_empty = 0;
    din_wr = 0; init_cmd = 0; dma_en_wr = 0; dma_req = 0;
    dma_done = 0; dma_tc = 0; reg_wr = 0;
  endtask

  task automatic wr(bit addr, logic [31:0] data);
    reg_wr = 1; reg_addr = addr; reg_wdata = data;
    tick();
  endtask

  task automatic rd(bit addr, logic [31:0] exp, string tag);
    reg_addr = addr;
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  task automatic chk_irq(bit exp, string tag);
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5 rst_n = 1;
    // R1 reset state
    rd(0, 32'h1, "R1 status after reset");
    rd(1, 32'h0, "R1 enable after reset");
    chk_irq(0, "R1 irq after reset");
    // R5 unmask input-ready
    wr(1, 32'h1);
    rd(1, 32'h1, "R6 enable readback");
    chk_irq(1, "R5 irq from ready");
    // R3 data write clears ready
    din_wr = 1; tick();
    rd(0, 32'h0, "R3 din_wr clears ready");
    chk_irq(0, "R5 irq after ready clear");
    buf_empty = 1; tick();
    rd(0, 32'h1, "R3 buf_empty sets ready");
    // R2/R3 write-1 no effect, R10 busy/dma read-only
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h1, "R10 write ones leaves status");
    wr(0, 32'h0);
    rd(0, 32'h0, "R3 software clear ready");
    // R2 digest
    final_done = 1; tick();
    rd(0, 32'h2, "R2 final_done sets digest");
    chk_irq(0, "R5 digest masked");
    wr(1, 32'h3);
    chk_irq(1, "R5 digest unmasked");
    wr(0, 32'h2);
    rd(0, 32'h2, "R2 write 1 keeps digest");
    init_cmd = 1; tick();
    rd(0, 32'h0, "R2 init clears digest");
    // R4 set wins
    final_done = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0; tick();
    rd(0, 32'h2, "R4 digest set beats write-0");
    buf_empty = 1; din_wr = 1; tick();
    rd(0, 32'h3, "R4 ready set beats din_wr");
    final_done = 1; init_cmd = 1; tick();
    rd(0, 32'h3, "R4 digest set beats init");
    // R6 enable upper bits
    wr(1, 32'hFFFF_FFFC);
    rd(1, 32'h0, "R6 upper enable bits ignored");
    chk_irq(0, "R5 all masked");
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h3, "R6 enable reads 3");
    // R7 busy, R10
    blk_start = 1; tick();
    rd(0, 32'hB, "R7 blk_start sets busy");
    wr(0, 32'h0);
    rd(0, 32'h8, "R10 status write keeps busy");
    blk_start = 1; blk_done = 1; tick();
    rd(0, 32'h8, "R7 start beats done");
    blk_done = 1; tick();
    rd(0, 32'h0, "R7 blk_done clears busy");
    blk_start = 1; tick();
    init_cmd = 1; tick();
    rd(0, 32'h0, "R7 init clears busy");
    // R8 / R9 DMA
    dma_en_wr = 1; dma_en_val = 1; tick();
    rd(0, 32'h4, "R8 dma enable shows active");
    wr(0, 32'h0);
    rd(0, 32'h4, "R10 status write keeps dma bit");
    dma_req = 1; tick();
    dma_en_wr = 1; dma_en_val = 0; tick();
    rd(0, 32'h4, "R8 in-flight holds active");
    dma_done = 1; tick();
    rd(0, 32'h0, "R8 done drops active");
    dma_en_wr = 1; dma_en_val = 1; tick();
    dma_tc = 1; dma_en_wr = 1; dma_en_val = 1; tick();
    rd(0, 32'h0, "R9 tc clears enable");
    dma_en_wr = 1; dma_en_val = 1; tick();
    init_cmd = 1; tick();
    rd(0, 32'h4, "R9 init keeps dma enable");
    dma_en_wr = 1; dma_en_val = 0; dma_req = 1; tick();
    init_cmd = 1; tick();
    rd(0, 32'h0, "R8 init ends transfer");
    repeat (4) tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule